// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block is a dynamic branch direction predictor for an in-order pipeline. The fetch stage presents the program counter, and the table returns a taken or not-taken guess. That guess travels with the instruction into decode. Once decode resolves the branch, it sends the same program counter and the real outcome back through an update port. The table then moves the selected entry one step toward that outcome.

Word-aligned program counters select an entry through their low bits. No tag is stored, so two branches whose low bits match share one entry. This sharing can cost accuracy but never correctness. A parameter selects the variant. The default keeps a four-state saturating counter per entry, and its guess only reverses after two wrong guesses in a row. The alternative keeps a single remembered outcome, so its guess reverses after every wrong guess.

Reset loads every entry with the weakly not-taken state. The load runs as a sweep of one entry per cycle. A ready flag reports when the sweep is over, and while it runs the reads return the reset state and updates are dropped.

Top module: `branch_history_table`

## Requirements
- R1: The entry index is program-counter bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). Bits [1:0] and all bits above the index have no effect, so addresses that differ only there read and update the same entry.
- R2: After reset, `table_ready` is low for exactly ENTRIES cycles and then stays high. From then on, every entry reads as state 01 until it is updated.
- R3: `rd_state` is the stored two-bit state. `rd_taken` is 1 for states 11 and 10 and 0 for states 01 and 00.
- R4: In the two-bit variant, a taken update raises the entry's state by one and stops at 11.
- R5: In the two-bit variant, a not-taken update lowers the entry's state by one and stops at 00.
- R6: In the two-bit variant, an entry at 11 still predicts taken after one not-taken update and predicts not taken after a second one. The reverse also holds for an entry at 00.
- R7: The values `rd_state` and `rd_taken` for the address on `rd_pc` appear after the next rising clock edge. Updates reach the table on that same edge.
- R8: When a read and an update select the same entry in the same cycle, the read returns the state from before the update.
- R9: In the one-bit variant (ONE_BIT=1), an update stores 11 for taken and 00 for not taken. A branch that closes a ten-iteration loop (nine taken, then one not taken) is mispredicted exactly twice on each pass through the loop.
- R10: While `table_ready` is low, reads return state 01 and updates leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the initialisation sweep |
| rd_pc | input | PC_W | Fetch program counter to look up |
| rd_state | output | 2 | Stored state of the looked-up entry, one cycle after `rd_pc` |
| rd_taken | output | 1 | Predicted direction for the looked-up entry |
| upd_en | input | 1 | Resolved branch update valid |
| upd_pc | input | PC_W | Program counter of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| table_ready | output | 1 | High once every entry holds the reset state |

## Verification
The assertions run on every cycle. They check that the ready flag never falls without a reset and that reads during the sweep return the reset state. They check that a same-cycle read of an entry being updated returns its previous value. They also check that re-reading an entry after an update shows exactly a single saturating step, or in the one-bit variant the stored outcome.

Some behaviours can only be shown by the bench's scenarios. These are the sharing of entries between aliased addresses and the two-miss hysteresis taken as a whole. They also include the exact length of the sweep and the count of two mispredictions per pass over a ten-iteration loop. The bench follows a long sweep of mixed outcomes over every entry of a small table against its own arithmetic model.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_NT_STRONG = 2'b00,
        CTR_NT_WEAK   = 2'b01,
        CTR_T_WEAK    = 2'b10,
        CTR_T_STRONG  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_NT_WEAK;

    typedef struct packed {
        logic en;
        logic taken;
    } resolve_t;

    typedef struct packed {
        logic taken;
        ctr_e state;
    } guess_t;

    function automatic logic ctr_direction(input ctr_e s);
        return s[1];
    endfunction

    function automatic ctr_e ctr_saturate(input ctr_e s, input logic taken);
        ctr_e r;
        unique case (s)
            CTR_NT_STRONG: r = taken ? CTR_NT_WEAK  : CTR_NT_STRONG;
            CTR_NT_WEAK:   r = taken ? CTR_T_WEAK   : CTR_NT_STRONG;
            CTR_T_WEAK:    r = taken ? CTR_T_STRONG : CTR_NT_WEAK;
            default:       r = taken ? CTR_T_STRONG : CTR_T_WEAK;
        endcase
        return r;
    endfunction

    function automatic ctr_e ctr_remember(input logic taken);
        return taken ? CTR_T_STRONG : CTR_NT_STRONG;
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    assign idx = pc[IDX_W+1:2];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};
endmodule

// File: rtl/bht_next.sv
module bht_next
    import bht_pkg::*;
#(
    parameter bit ONE_BIT = 1'b0
) (
    input  ctr_e cur,
    input  logic taken,
    output ctr_e nxt
);
    generate
        if (ONE_BIT) begin : g_one_bit
            ctr_e unused_cur;
            assign unused_cur = cur;
            assign nxt = ctr_remember(taken);
        end else begin : g_two_bit
            assign nxt = ctr_saturate(cur, taken);
        end
    endgenerate
endmodule

// File: rtl/bht_store.sv
module bht_store
    import bht_pkg::*;
#(
    parameter int ENTRIES = 4096,
    parameter int IDX_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_state,
    input  logic [IDX_W-1:0] look_idx,
    output ctr_e             look_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_e             wr_state,
    output logic             ready
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    ctr_e             cells [ENTRIES];
    logic [IDX_W-1:0] sweep_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b1;
            sweep_q <= '0;
        end else if (busy_q) begin
            sweep_q <= sweep_q + 1'b1;
            if (sweep_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (busy_q) begin
            cells[sweep_q] <= CTR_RESET;
        end else if (wr_en && !rst) begin
            cells[wr_idx] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || busy_q) begin
            rd_state <= CTR_RESET;
        end else begin
            rd_state <= cells[rd_idx];
        end
    end

    assign look_state = cells[look_idx];
    assign ready      = ~busy_q;
endmodule

// File: rtl/branch_history_table.sv
module branch_history_table
    import bht_pkg::*;
#(
    parameter int ENTRIES = 4096,
    parameter int PC_W    = 32,
    parameter bit ONE_BIT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] rd_pc,
    output logic [1:0]      rd_state,
    output logic            rd_taken,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            table_ready
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] up_idx;
    resolve_t         resolve;
    ctr_e             old_state;
    ctr_e             new_state;
    ctr_e             fetch_state;
    guess_t           guess;

    assign resolve = '{en: upd_en, taken: upd_taken};

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rd_index (
        .pc  (rd_pc),
        .idx (rd_idx)
    );

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_index (
        .pc  (upd_pc),
        .idx (up_idx)
    );

    bht_next #(.ONE_BIT(ONE_BIT)) u_next (
        .cur   (old_state),
        .taken (resolve.taken),
        .nxt   (new_state)
    );

    bht_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (rd_idx),
        .rd_state   (fetch_state),
        .look_idx   (up_idx),
        .look_state (old_state),
        .wr_en      (resolve.en),
        .wr_idx     (up_idx),
        .wr_state   (new_state),
        .ready      (table_ready)
    );

    assign guess    = '{taken: ctr_direction(fetch_state), state: fetch_state};
    assign rd_state = guess.state;
    assign rd_taken = guess.taken;
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
    parameter int ENTRIES = 4096,
    parameter int PC_W    = 32,
    parameter bit ONE_BIT = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] rd_pc,
    input logic [1:0]      rd_state,
    input logic            upd_en,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic            table_ready
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] ri;
    logic [IDX_W-1:0] ui;
    assign ri = rd_pc[IDX_W+1:2];
    assign ui = upd_pc[IDX_W+1:2];

    function automatic logic [1:0] up1(input logic [1:0] s);
        return (s == 2'b11) ? 2'b11 : s + 2'b01;
    endfunction
    function automatic logic [1:0] dn1(input logic [1:0] s);
        return (s == 2'b00) ? 2'b00 : s - 2'b01;
    endfunction

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        table_ready |=> table_ready); // R2

    AST_SWEEP_READS_RESET: assert property (@(posedge clk) disable iff (rst)
        !table_ready |=> rd_state == 2'b01); // R10

    AST_OLD_ON_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (table_ready && $past(table_ready) && !$past(rst) && ri == $past(ri)
         && !$past(upd_en && ui == ri)) |=> $stable(rd_state)); // R8

    generate
        if (ONE_BIT) begin : g_one
            AST_ONE_BIT_STORE: assert property (@(posedge clk) disable iff (rst)
                ($past(table_ready && upd_en && ui == ri) && !$past(rst)
                 && table_ready && ri == $past(ri))
                |=> rd_state == {2{$past(upd_taken, 2)}}); // R9
        end else begin : g_two
            AST_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
                ($past(table_ready && upd_en && upd_taken && ui == ri) && !$past(rst)
                 && table_ready && ri == $past(ri))
                |=> rd_state == up1($past(rd_state))); // R4
            AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
                ($past(table_ready && upd_en && !upd_taken && ui == ri) && !$past(rst)
                 && table_ready && ri == $past(ri))
                |=> rd_state == dn1($past(rd_state))); // R5
        end
    endgenerate
endmodule

bind branch_history_table bht_checker #(
    .ENTRIES (ENTRIES),
    .PC_W    (PC_W),
    .ONE_BIT (ONE_BIT)
) u_bht_checker (
    .clk         (clk),
    .rst         (rst),
    .rd_pc       (rd_pc),
    .rd_state    (rd_state),
    .upd_en      (upd_en),
    .upd_pc      (upd_pc),
    .upd_taken   (upd_taken),
    .table_ready (table_ready)
);

// File: tb/test_branch_history_table.sv
module test_branch_history_table;
    localparam int ENT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rd_pc = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  st_a, st_b;
    logic        tk_a, tk_b, rdy_a, rdy_b;

    int n_cmp = 0;
    int n_bad = 0;
    int m2 [ENT];
    int m1 [ENT];
    int post = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    branch_history_table #(.ENTRIES(ENT), .PC_W(32), .ONE_BIT(1'b0)) i_branch_history_table (
        .clk(clk), .rst(rst), .rd_pc(rd_pc), .rd_state(st_a), .rd_taken(tk_a),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .table_ready(rdy_a));

    branch_history_table #(.ENTRIES(ENT), .PC_W(32), .ONE_BIT(1'b1)) i_branch_history_table_1b (
        .clk(clk), .rst(rst), .rd_pc(rd_pc), .rd_state(st_b), .rd_taken(tk_b),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .table_ready(rdy_b));

    function automatic logic [31:0] mkpc(input int idx, input int hi, input int lo);
        return 32'((hi << 6) | ((idx & (ENT - 1)) << 2) | (lo & 3));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(st_a == 2'b01 && tk_a == 1'b0, "R2 reset read two-bit", int'(st_a), 1);
        chk(st_b == 2'b01 && rdy_b == 1'b0, "R2 reset read one-bit", int'(st_b), 1);
        chk(rdy_a == 1'b0, "R2 ready low in reset", int'(rdy_a), 0);
        rst = 1'b0;
        post = 0;
        for (int i = 0; i < ENT; i++) begin
            m2[i] = 1;
            m1[i] = 1;
        end
    endtask

    task automatic step(input logic [31:0] rpc, input bit ue, input logic [31:0] upc,
                        input bit ut, input string tag);
        int ri, ui, e2, e1;
        bit busy;
        rd_pc = rpc; upd_en = ue; upd_pc = upc; upd_taken = ut;
        ri = int'(rpc[5:2]);
        ui = int'(upc[5:2]);
        busy = (post < ENT);
        e2 = busy ? 1 : m2[ri];
        e1 = busy ? 1 : m1[ri];
        if (ue && !busy) begin
            m2[ui] = ut ? ((m2[ui] == 3) ? 3 : m2[ui] + 1) : ((m2[ui] == 0) ? 0 : m2[ui] - 1);
            m1[ui] = ut ? 3 : 0;
        end
        @(posedge clk);
        post++;
        @(negedge clk);
        chk(int'(st_a) == e2 && int'(tk_a) == (e2 >> 1), {tag, " two-bit"}, int'(st_a), e2);
        chk(int'(st_b) == e1 && int'(tk_b) == (e1 >> 1), {tag, " one-bit"}, int'(st_b), e1);
        chk(rdy_a == (post >= ENT), {tag, " ready"}, int'(rdy_a), int'(post >= ENT));
        upd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int miss;
        @(negedge clk);
        do_reset();
        // R10: updates during the sweep are dropped, reads give 01; R2 ready timing
        for (int i = 0; i < ENT; i++) step(mkpc(i, 0, 0), 1'b1, mkpc(3, 0, 0), 1'b1, "R10 R2 sweep");
        // R2: every entry holds 01 once ready
        for (int i = 0; i < ENT; i++) step(mkpc(i, 1, 0), 1'b0, '0, 1'b0, "R2 all entries");
        // R4 R5 R8 R7 R3: exhaustive mixed-outcome sweep, read collides with update
        for (int i = 0; i < ENT; i++) begin
            for (int k = 0; k < 12; k++) begin
                step(mkpc(i, k, k), 1'b1, mkpc(i, i, 0), bit'(((i * 5 + k * k + k / 3) >> 1) & 1),
                     "R4 R5 R8 sweep");
            end
            step(mkpc(i, 2, 3), 1'b0, '0, 1'b0, "R7 R3 readback");
        end
        // R4: saturate at 11
        for (int k = 0; k < 5; k++) step(mkpc(0, 0, 0), 1'b1, mkpc(5, 0, 0), 1'b1, "R4 climb");
        step(mkpc(5, 0, 0), 1'b0, '0, 1'b0, "R4 saturate");
        chk(st_a == 2'b11, "R4 top state", int'(st_a), 3);
        // R5: saturate at 00
        for (int k = 0; k < 5; k++) step(mkpc(0, 0, 0), 1'b1, mkpc(5, 0, 0), 1'b0, "R5 fall");
        step(mkpc(5, 0, 0), 1'b0, '0, 1'b0, "R5 saturate");
        chk(st_a == 2'b00, "R5 bottom state", int'(st_a), 0);
        // R6: hysteresis from strong taken
        for (int k = 0; k < 4; k++) step(mkpc(0, 0, 0), 1'b1, mkpc(9, 0, 0), 1'b1, "R6 prime");
        step(mkpc(0, 0, 0), 1'b1, mkpc(9, 0, 0), 1'b0, "R6 miss one");
        step(mkpc(9, 0, 0), 1'b0, '0, 1'b0, "R6 after one");
        chk(tk_a == 1'b1, "R6 still taken after one miss", int'(tk_a), 1);
        step(mkpc(0, 0, 0), 1'b1, mkpc(9, 0, 0), 1'b0, "R6 miss two");
        step(mkpc(9, 0, 0), 1'b0, '0, 1'b0, "R6 after two");
        chk(tk_a == 1'b0, "R6 flips after two misses", int'(tk_a), 0);
        // R1: aliasing through upper bits and low two bits
        for (int k = 0; k < 3; k++) step(mkpc(0, 0, 0), 1'b1, mkpc(7, 12'hABC, 2), 1'b1, "R1 alias update");
        step(mkpc(7, 12'h123, 1), 1'b0, '0, 1'b0, "R1 alias read");
        chk(tk_a == 1'b1, "R1 alias shares entry", int'(tk_a), 1);
        // R9: one-bit loop closer, ten iterations, three passes
        do_reset();
        for (int i = 0; i < ENT; i++) step(mkpc(i, 0, 0), 1'b0, '0, 1'b0, "R2 second sweep");
        for (int run = 0; run < 3; run++) begin
            miss = 0;
            for (int it = 0; it < 10; it++) begin
                step(mkpc(12, run, 0), 1'b0, '0, 1'b0, "R9 loop predict");
                if (tk_b != (it < 9)) miss++;
                step(mkpc(1, 0, 0), 1'b1, mkpc(12, it, 0), bit'(it < 9), "R9 loop resolve");
            end
            chk(miss == 2, "R9 mispredicts per pass", miss, 2);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule